// File: doc/BRIEF.md
# I2C Controller Interrupt and Status Unit

This block keeps the event status, interrupt enables, interrupt vector and DMA configuration of a register-mapped I2C master controller. The transfer engine sends single-cycle event pulses (access-ready, no-acknowledge, receive-ready, transmit-ready, transmit-underflow, receive-overrun and start-byte-detected). Each pulse sets a sticky status bit. Software reads these bits through a small register port. It reads the status word with the live bus-busy flag merged in. It can also read a vector register, which reports the lowest pending enabled source and acknowledges it in the same access.

The block drives one level interrupt line and two DMA request lines. Each DMA request line follows a ready flag while its DMA enable is set. Turning on a DMA path also removes the matching ready source from the interrupt enables, so the DMA engine gets the request and the CPU does not. The receive-ready and transmit-ready flags cannot be cleared by a status write. Only the engine's clear strobes and the vector read remove them.

Registers sit at byte offsets in steps of four, with 16-bit data: 0x00 revision, 0x04 interrupt enable, 0x08 status, 0x0C vector, 0x10 system status, 0x14 DMA configuration. Reads have no wait state. Read data is combinational from the current state, and the side effects of an access take hold at the clock edge that ends it.

Top module: `i2c_irq_status`

## Requirements
- R1: `irq` is high exactly when at least one of status bits 5..0 is set while the interrupt-enable bit of the same position is also set.
- R2: The event inputs set sticky status bits: no-acknowledge bit 1, access-ready bit 2, receive-ready bit 3, transmit-ready bit 4, transmit-underflow bit 10, receive-overrun bit 11, start-byte-detected bit 15. All other stored bits read 0.
- R3: A read of offset 0x08 returns the stored status with `bus_busy` placed in bit 12.
- R4: A read of offset 0x0C returns 1 plus the position of the lowest set bit of (status AND enable), or 0 when there is none. When the result is nonzero, that status bit is cleared at the end of the read.
- R5: A write to offset 0x08 clears the status bits that are set in (write data AND 0x0027), and no others. Receive-ready and transmit-ready are cleared only by `hw_clr_rrdy` and `hw_clr_xrdy` (or by R4).
- R6: A write to offset 0x04 stores only data bits 5..0. A read returns them with the upper bits zero.
- R7: A write to offset 0x14 stores only bits 15 (receive DMA enable) and 7 (transmit DMA enable). Writing bit 15 as 1 clears enable bit 3, and writing bit 7 as 1 clears enable bit 4.
- R8: `dma_rx_req` equals status bit 3 while receive DMA is enabled, and 0 otherwise. `dma_tx_req` equals status bit 4 while transmit DMA is enabled, and 0 otherwise.
- R9: Writes to offsets 0x00, 0x0C and 0x10 change nothing. Offset 0x00 reads the `REV_ID` parameter, and offset 0x10 reads 0.
- R10: An event pulse in the same cycle as any clear of its bit (status write, vector read or hardware clear) wins, and the bit stays set.
- R11: After reset, the status, enables and DMA enables are all 0, and all three outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (qualifies side effects) |
| reg_addr | input | AW | Byte offset of the register |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr` |
| bus_busy | input | 1 | Live bus-busy flag from the engine |
| ev_ardy | input | 1 | Access-ready event pulse |
| ev_nack | input | 1 | No-acknowledge event pulse |
| ev_rrdy | input | 1 | Receive-ready event pulse |
| ev_xrdy | input | 1 | Transmit-ready event pulse |
| ev_xudf | input | 1 | Transmit-underflow event pulse |
| ev_rovr | input | 1 | Receive-overrun event pulse |
| ev_sbd | input | 1 | Start-byte-detected event pulse |
| hw_clr_rrdy | input | 1 | Engine clear of receive-ready |
| hw_clr_xrdy | input | 1 | Engine clear of transmit-ready |
| irq | output | 1 | Interrupt request |
| dma_rx_req | output | 1 | Receive DMA request |
| dma_tx_req | output | 1 | Transmit DMA request |

## Verification
The bench builds the block with `AW` = 6 and `REV_ID` = 16'h003A. The non-default revision makes the read of offset 0x00 tell the parameter apart from a stale or written value. With the six-bit offset, every register, including the read-only and ignored ones, can be reached as a separate address. With these values the bench walks the vector priority through all four enabled sources down to zero. It also sets events in the same cycle as each kind of clear, and enables DMA on top of an interrupt-enable mask that is fully set.

// File: rtl/i2c_irq_status.sv
module i2c_irq_status #(
  parameter int          AW     = 6,
  parameter logic [15:0] REV_ID = 16'h0034
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [AW-1:0] reg_addr,
  input  logic [15:0]   reg_wdata,
  output logic [15:0]   reg_rdata,
  input  logic          bus_busy,
  input  logic          ev_ardy,
  input  logic          ev_nack,
  input  logic          ev_rrdy,
  input  logic          ev_xrdy,
  input  logic          ev_xudf,
  input  logic          ev_rovr,
  input  logic          ev_sbd,
  input  logic          hw_clr_rrdy,
  input  logic          hw_clr_xrdy,
  output logic          irq,
  output logic          dma_rx_req,
  output logic          dma_tx_req
);
  localparam int DW = 16;
  localparam int IEW = 6;
  localparam int VW = $clog2(IEW + 1);
  localparam logic [AW-1:0] A_REV  = AW'(8'h00);
  localparam logic [AW-1:0] A_IE   = AW'(8'h04);
  localparam logic [AW-1:0] A_STAT = AW'(8'h08);
  localparam logic [AW-1:0] A_VEC  = AW'(8'h0C);
  localparam logic [AW-1:0] A_SYS  = AW'(8'h10);
  localparam logic [AW-1:0] A_DMA  = AW'(8'h14);
  localparam int B_NACK = 1, B_ARDY = 2, B_RRDY = 3, B_XRDY = 4;
  localparam int B_XUDF = 10, B_ROVR = 11, B_BUSY = 12, B_SBD = 15;
  localparam logic [DW-1:0] SW_CLR_MASK = 16'h0027;
  localparam int B_RXEN = 15, B_TXEN = 7;

  logic [DW-1:0]  stat_q;
  logic [IEW-1:0] ie_q;
  logic           rx_en_q, tx_en_q;

  logic [IEW-1:0] pend;
  logic [VW-1:0]  vec_idx;
  logic [DW-1:0]  set_v, clr_v, vec_clr;
  logic           wr_ie, wr_stat, wr_dma, rd_vec;

  assign wr_ie   = reg_wr && reg_addr == A_IE;
  assign wr_stat = reg_wr && reg_addr == A_STAT;
  assign wr_dma  = reg_wr && reg_addr == A_DMA;
  assign rd_vec  = reg_rd && reg_addr == A_VEC;

  assign pend = stat_q[IEW-1:0] & ie_q;

  always_comb begin
    vec_idx = '0;
    for (int i = IEW - 1; i >= 0; i--)
      if (pend[i]) vec_idx = VW'(i + 1);
  end

  always_comb begin
    vec_clr = '0;
    if (vec_idx != '0) vec_clr[vec_idx - 1'b1] = 1'b1;
  end

  always_comb begin
    set_v = '0;
    set_v[B_NACK] = ev_nack;
    set_v[B_ARDY] = ev_ardy;
    set_v[B_RRDY] = ev_rrdy;
    set_v[B_XRDY] = ev_xrdy;
    set_v[B_XUDF] = ev_xudf;
    set_v[B_ROVR] = ev_rovr;
    set_v[B_SBD]  = ev_sbd;
  end

  always_comb begin
    clr_v = '0;
    if (wr_stat) clr_v = reg_wdata & SW_CLR_MASK;
    if (rd_vec)  clr_v = clr_v | vec_clr;
    clr_v[B_RRDY] = clr_v[B_RRDY] | hw_clr_rrdy;
    clr_v[B_XRDY] = clr_v[B_XRDY] | hw_clr_xrdy;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q  <= '0;
      ie_q    <= '0;
      rx_en_q <= 1'b0;
      tx_en_q <= 1'b0;
    end else begin
      stat_q <= (stat_q & ~clr_v) | set_v;
      if (wr_ie) ie_q <= reg_wdata[IEW-1:0];
      if (wr_dma) begin
        rx_en_q <= reg_wdata[B_RXEN];
        tx_en_q <= reg_wdata[B_TXEN];
        if (reg_wdata[B_RXEN]) ie_q[B_RRDY] <= 1'b0;
        if (reg_wdata[B_TXEN]) ie_q[B_XRDY] <= 1'b0;
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_REV:  reg_rdata = REV_ID;
      A_IE:   reg_rdata = DW'(ie_q);
      A_STAT: begin
        reg_rdata = stat_q;
        reg_rdata[B_BUSY] = bus_busy;
      end
      A_VEC:  reg_rdata = DW'(vec_idx);
      A_SYS:  reg_rdata = '0;
      A_DMA: begin
        reg_rdata[B_RXEN] = rx_en_q;
        reg_rdata[B_TXEN] = tx_en_q;
      end
      default: reg_rdata = '0;
    endcase
  end

  assign irq        = |pend;
  assign dma_rx_req = rx_en_q & stat_q[B_RRDY];
  assign dma_tx_req = tx_en_q & stat_q[B_XRDY];

endmodule

// File: rtl/i2c_irq_status_chk.sv
module i2c_irq_status_chk #(
  parameter int AW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reg_wr,
  input logic          reg_rd,
  input logic [AW-1:0] reg_addr,
  input logic [15:0]   reg_wdata,
  input logic [15:0]   reg_rdata,
  input logic          bus_busy,
  input logic          ev_nack,
  input logic          ev_rrdy,
  input logic          hw_clr_rrdy,
  input logic          irq,
  input logic          dma_rx_req,
  input logic [15:0]   stat_q,
  input logic [5:0]    ie_q
);
  logic rd_vec, rd_stat, wr_ie, wr_dma;
  assign rd_vec  = reg_rd && reg_addr == AW'(8'h0C);
  assign rd_stat = reg_rd && reg_addr == AW'(8'h08);
  assign wr_ie   = reg_wr && reg_addr == AW'(8'h04);
  assign wr_dma  = reg_wr && reg_addr == AW'(8'h14);

  p_vec_matches_irq_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_vec |-> ((reg_rdata != 16'h0) == irq));

  p_busy_merge_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stat |-> (reg_rdata[12] == bus_busy));

  p_ie_store_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ie |=> (ie_q == $past(reg_wdata[5:0])));

  p_dma_drops_ie_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_dma && reg_wdata[15]) |=> !ie_q[3]);

  p_rxreq_needs_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    dma_rx_req |-> stat_q[3]);

  p_event_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ev_nack |=> stat_q[1]);

  p_rrdy_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_q[3] && !hw_clr_rrdy && !rd_vec) |=> stat_q[3]);

  p_rrdy_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rrdy |=> stat_q[3]);
endmodule

bind i2c_irq_status i2c_irq_status_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
  .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
  .bus_busy(bus_busy), .ev_nack(ev_nack), .ev_rrdy(ev_rrdy),
  .hw_clr_rrdy(hw_clr_rrdy), .irq(irq), .dma_rx_req(dma_rx_req),
  .stat_q(stat_q), .ie_q(ie_q)
);

// File: tb/i2c_irq_status_tb.sv
module i2c_irq_status_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 6;
  localparam logic [15:0] REV = 16'h003A;
  localparam int NTBL = 15;
  // {read, addr, data-or-expected}
  localparam logic [22:0] TBL [NTBL] = '{
    {1'b0, 6'h04, 16'hFFFF}, {1'b1, 6'h04, 16'h003F},
    {1'b0, 6'h14, 16'hFFFF}, {1'b1, 6'h14, 16'h8080},
    {1'b1, 6'h04, 16'h0027}, {1'b0, 6'h14, 16'h0000},
    {1'b1, 6'h14, 16'h0000}, {1'b1, 6'h04, 16'h0027},
    {1'b0, 6'h00, 16'h1234}, {1'b1, 6'h00, REV},
    {1'b0, 6'h0C, 16'hFFFF}, {1'b1, 6'h0C, 16'h0000},
    {1'b0, 6'h10, 16'hFFFF}, {1'b1, 6'h10, 16'h0000},
    {1'b1, 6'h08, 16'h0000}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 0, reg_rd = 0, bus_busy = 0;
  logic [AW-1:0] reg_addr = '0;
  logic [15:0] reg_wdata = '0, reg_rdata;
  logic [6:0] ev = '0;  // 0 ardy 1 nack 2 rrdy 3 xrdy 4 xudf 5 rovr 6 sbd
  logic [1:0] hwc = '0; // 0 rrdy 1 xrdy
  logic irq, dma_rx_req, dma_tx_req;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_irq_status #(.AW(AW), .REV_ID(REV)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .bus_busy(bus_busy), .ev_ardy(ev[0]), .ev_nack(ev[1]), .ev_rrdy(ev[2]),
    .ev_xrdy(ev[3]), .ev_xudf(ev[4]), .ev_rovr(ev[5]), .ev_sbd(ev[6]),
    .hw_clr_rrdy(hwc[0]), .hw_clr_xrdy(hwc[1]),
    .irq(irq), .dma_rx_req(dma_rx_req), .dma_tx_req(dma_tx_req));

  task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic cyc(input logic wr, input logic [AW-1:0] a, input logic [15:0] d,
                     input logic [6:0] e, input logic [1:0] h);
    @(negedge clk);
    reg_wr = wr; reg_addr = a; reg_wdata = d; ev = e; hwc = h;
    @(posedge clk); #1;
    reg_wr = 0; ev = '0; hwc = '0;
  endtask

  task automatic rd_chk(input logic [AW-1:0] a, input logic [15:0] exp, input string tag);
    @(negedge clk);
    reg_rd = 1; reg_addr = a; #1;
    check(tag, reg_rdata, exp);
    @(posedge clk); #1;
    reg_rd = 0;
  endtask

  task automatic out_chk(input logic [2:0] exp, input string tag);
    @(negedge clk);
    check(tag, {13'h0, irq, dma_rx_req, dma_tx_req}, {13'h0, exp});
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    out_chk(3'b000, "R11 reset outputs");
    rst_n = 1;
    rd_chk(6'h08, 16'h0000, "R11 reset status");
    rd_chk(6'h04, 16'h0000, "R11 reset enables");

    // register table: R6 R7 R9
    for (int i = 0; i < NTBL; i++) begin
      if (TBL[i][22]) rd_chk(TBL[i][21:16], TBL[i][15:0], "R6/R7/R9 table read");
      else cyc(1'b1, TBL[i][21:16], TBL[i][15:0], '0, '0);
    end

    // R2 R3 R1: all events
    cyc(1'b1, 6'h04, 16'h003F, '0, '0);
    bus_busy = 1;
    cyc(1'b0, '0, '0, 7'h7F, '0);
    rd_chk(6'h08, 16'h9C1E, "R2 R3 status with busy");
    out_chk(3'b100, "R1 irq pending");

    // R4 vector priority
    rd_chk(6'h0C, 16'd2, "R4 vector nack");
    rd_chk(6'h0C, 16'd3, "R4 vector ardy");
    rd_chk(6'h0C, 16'd4, "R4 vector rrdy");
    rd_chk(6'h0C, 16'd5, "R4 vector xrdy");
    rd_chk(6'h0C, 16'd0, "R4 vector empty");
    bus_busy = 0;
    rd_chk(6'h08, 16'h8C00, "R3 R4 status after vectors");
    out_chk(3'b000, "R1 irq idle");

    // R5 software vs hardware clears
    cyc(1'b0, '0, '0, 7'h0F, '0);
    cyc(1'b1, 6'h08, 16'hFFFF, '0, '0);
    rd_chk(6'h08, 16'h8C18, "R5 write clears only 0x27 bits");
    cyc(1'b0, '0, '0, '0, 2'b01);
    rd_chk(6'h08, 16'h8C10, "R5 hw clear rrdy");
    cyc(1'b0, '0, '0, '0, 2'b10);
    rd_chk(6'h08, 16'h8C00, "R5 hw clear xrdy");

    // R10 set wins
    cyc(1'b1, 6'h08, 16'h0002, 7'h02, '0);
    rd_chk(6'h08, 16'h8C02, "R10 nack set beats write clear");
    cyc(1'b1, 6'h08, 16'h0002, '0, '0);
    rd_chk(6'h08, 16'h8C00, "R5 nack cleared by write");
    cyc(1'b0, '0, '0, 7'h04, 2'b01);
    rd_chk(6'h08, 16'h8C08, "R10 rrdy set beats hw clear");
    cyc(1'b0, '0, '0, '0, 2'b01);

    // R7 R8 DMA
    cyc(1'b1, 6'h14, 16'h8080, '0, '0);
    rd_chk(6'h04, 16'h0027, "R7 dma drops ready enables");
    cyc(1'b0, '0, '0, 7'h04, '0);
    out_chk(3'b010, "R8 rx request, R1 no irq");
    cyc(1'b0, '0, '0, 7'h08, '0);
    out_chk(3'b011, "R8 tx request");
    cyc(1'b1, 6'h14, 16'h0000, '0, '0);
    out_chk(3'b000, "R8 requests low when disabled");
    cyc(1'b1, 6'h14, 16'h0080, '0, '0);
    out_chk(3'b001, "R8 tx only");

    // R1 mask gating
    cyc(1'b1, 6'h04, 16'h0000, '0, '0);
    cyc(1'b0, '0, '0, 7'h02, '0);
    out_chk(3'b001, "R1 masked nack");
    cyc(1'b1, 6'h04, 16'h0002, '0, '0);
    out_chk(3'b101, "R1 enabled nack");

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule